// File: doc/BRIEF.md
# Dialing Timing Constraint Supervisor

This block watches a single telephone line while a caller enters a number. It is driven by a hook level (high while the handset is lifted), a one-cycle strobe for each dialed digit, and a periodic time-base tick. With the default parameters one tick is 10 ms. When the handset comes up, the block gives dial tone. From then on it enforces several timing windows together:
- a maximum time from dial tone to the first digit;
- a maximum gap and a minimum gap between consecutive digits;
- a maximum total time for entering the whole number.

All windows are counted in ticks. When a maximum window runs out, the timer expiry acts as an event that drives the controller into its error state. A correct number ends with a one-cycle completion pulse. A broken rule leaves a sticky 3-bit violation code that holds until the handset is put down.

The controller has five states. IDLE waits for the handset to come up. TONE gives dial tone and waits for the first digit. COLLECT accepts the remaining digits. DONE holds after a full number. ERROR holds a violation. The transitions are as follows:
- IDLE goes to TONE on the first clock with the handset up.
- TONE goes to COLLECT on the first digit.
- TONE goes to ERROR on first-digit expiry or on total expiry.
- COLLECT goes to DONE on the last digit.
- COLLECT goes to ERROR on gap expiry, on a too-fast digit or on total expiry.
- Every state goes to IDLE when the handset is put down.

Top module: `dial_supervisor`

## Requirements
- R1: While reset is applied, and in the first cycles after it, dial_tone and number_done are 0 and viol_code is 0 (no violation).
- R2: When the handset is up in IDLE, dial_tone is 1 on the following cycle. This is within one tick.
- R3: dial_tone stays 1 in TONE and goes to 0 on the cycle after the first digit strobe is accepted.
- R4: If FIRST_MAX_TICKS ticks pass in TONE with no digit, the block enters ERROR with viol_code = 1 (first-digit timeout).
- R5: If GAP_MAX_TICKS ticks pass in COLLECT since the last accepted digit, the block enters ERROR with viol_code = 2 (inter-digit timeout).
- R6: A digit that arrives in COLLECT fewer than GAP_MIN_TICKS ticks after the previous accepted digit gives ERROR with viol_code = 3 (too fast).
- R7: If TOTAL_MAX_TICKS ticks pass since dial tone started without a full number, the block enters ERROR with viol_code = 4 (overall timeout). When the first-digit or inter-digit window expires on the same tick, code 1 or 2 is reported instead.
- R8: A digit strobe in the same cycle as the tick that would expire a maximum window is accepted, and no timeout is raised in that cycle.
- R9: Accepting digit number NUM_DIGITS within every window pulses number_done for exactly one cycle and moves to DONE. Further digits and ticks in DONE change no output.
- R10: viol_code holds the first violation detected. It does not change while the handset stays up, whatever digits or ticks follow.
- R11: With the handset down, on the next cycle the block is in IDLE with dial_tone, number_done and viol_code all 0, from any state.
- R12: Digit strobes while the handset is down are ignored. After the handset is lifted, the number entry starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| off_hook | input | 1 | High while the handset is lifted |
| digit_stb | input | 1 | One-cycle pulse per dialed digit |
| tick | input | 1 | Time-base tick, one cycle wide |
| dial_tone | output | 1 | Dial tone request, high in TONE |
| number_done | output | 1 | One-cycle pulse when a full number is accepted |
| viol_code | output | 3 | 0 = none, 1 = first-digit timeout, 2 = inter-digit timeout, 3 = too fast, 4 = overall timeout |

## Verification
The bench builds the block with the following parameters: first-digit window 12 ticks, maximum gap 10 ticks, minimum gap 3 ticks, total window 30 ticks, and 4 digits per number. With windows this short, every timeout and the complete-number path take only tens of cycles. They also make it easy to line up exact collisions, such as a digit on the very tick that would expire its gap window, or the gap and total windows running out on the same tick, so that the priority between codes can be observed. Random calls with ticks on about three cycles in four, random digit rates and random hang-ups then cover the ways the windows interleave.

// File: rtl/dsv_pkg.sv
package dsv_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_TONE    = 3'd1,
        S_COLLECT = 3'd2,
        S_DONE    = 3'd3,
        S_ERROR   = 3'd4
    } dsv_state_e;

    typedef enum logic [2:0] {
        V_NONE      = 3'd0,
        V_FIRST_TO  = 3'd1,
        V_GAP_TO    = 3'd2,
        V_TOO_FAST  = 3'd3,
        V_TOTAL_TO  = 3'd4
    } dsv_viol_e;

endpackage

// File: rtl/dsv_tick_cnt.sv
// Saturating tick counter with synchronous clear; clear wins over count.
module dsv_tick_cnt #(
    parameter int CAP = 3000,
    localparam int W  = $clog2(CAP + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CAP_V = W'(CAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && (cnt != CAP_V)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dsv_digit_cnt.sv
// Counts accepted digits; flags when the next accepted digit completes a number.
module dsv_digit_cnt #(
    parameter int NUM_DIGITS = 7,
    localparam int W = $clog2(NUM_DIGITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_next
);
    localparam logic [W-1:0] LAST_V = W'(NUM_DIGITS - 1);
    localparam logic [W-1:0] FULL_V = W'(NUM_DIGITS);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != FULL_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last_next = (cnt == LAST_V);
endmodule

// File: rtl/dial_supervisor.sv
module dial_supervisor
    import dsv_pkg::*;
#(
    parameter int FIRST_MAX_TICKS = 3000,
    parameter int GAP_MAX_TICKS   = 2000,
    parameter int GAP_MIN_TICKS   = 50,
    parameter int TOTAL_MAX_TICKS = 3000,
    parameter int NUM_DIGITS      = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       off_hook,
    input  logic       digit_stb,
    input  logic       tick,
    output logic       dial_tone,
    output logic       number_done,
    output logic [2:0] viol_code
);
    localparam int GAP_CAP = (FIRST_MAX_TICKS > GAP_MAX_TICKS) ? FIRST_MAX_TICKS : GAP_MAX_TICKS;
    localparam int GAP_W   = $clog2(GAP_CAP + 1);
    localparam int TOT_W   = $clog2(TOTAL_MAX_TICKS + 1);

    localparam logic [GAP_W-1:0] FIRST_LAST = GAP_W'(FIRST_MAX_TICKS - 1);
    localparam logic [GAP_W-1:0] GAP_LAST   = GAP_W'(GAP_MAX_TICKS - 1);
    localparam logic [GAP_W-1:0] GAP_MIN_V  = GAP_W'(GAP_MIN_TICKS);
    localparam logic [TOT_W-1:0] TOT_LAST   = TOT_W'(TOTAL_MAX_TICKS - 1);

    dsv_state_e       state, nxt;
    dsv_viol_e        code_n;
    logic             accept;
    logic             last_next;
    logic [GAP_W-1:0] gap_cnt;
    logic [TOT_W-1:0] tot_cnt;
    logic             in_idle;

    assign in_idle = (state == S_IDLE);

    // Ticks since dial tone started, or since the last accepted digit
    dsv_tick_cnt #(.CAP(GAP_CAP)) u_gap_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (in_idle || accept),
        .tick  (tick),
        .cnt   (gap_cnt)
    );

    // Ticks since dial tone started
    dsv_tick_cnt #(.CAP(TOTAL_MAX_TICKS)) u_tot_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (in_idle),
        .tick  (tick),
        .cnt   (tot_cnt)
    );

    dsv_digit_cnt #(.NUM_DIGITS(NUM_DIGITS)) u_dig_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (in_idle),
        .inc       (accept),
        .last_next (last_next)
    );

    // Next-state logic: a digit beats a timer expiring on the same cycle;
    // a first-digit or gap expiry beats a total expiry.
    always_comb begin
        nxt    = state;
        code_n = V_NONE;
        accept = 1'b0;
        if (!off_hook) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: nxt = S_TONE;
                S_TONE: begin
                    if (digit_stb) begin
                        accept = 1'b1;
                        nxt    = S_COLLECT;
                    end else if (tick && (gap_cnt >= FIRST_LAST)) begin
                        nxt    = S_ERROR;
                        code_n = V_FIRST_TO;
                    end else if (tick && (tot_cnt >= TOT_LAST)) begin
                        nxt    = S_ERROR;
                        code_n = V_TOTAL_TO;
                    end
                end
                S_COLLECT: begin
                    if (digit_stb) begin
                        if (gap_cnt < GAP_MIN_V) begin
                            nxt    = S_ERROR;
                            code_n = V_TOO_FAST;
                        end else begin
                            accept = 1'b1;
                            if (last_next) nxt = S_DONE;
                        end
                    end else if (tick && (gap_cnt >= GAP_LAST)) begin
                        nxt    = S_ERROR;
                        code_n = V_GAP_TO;
                    end else if (tick && (tot_cnt >= TOT_LAST)) begin
                        nxt    = S_ERROR;
                        code_n = V_TOTAL_TO;
                    end
                end
                S_DONE:  nxt = S_DONE;
                S_ERROR: nxt = S_ERROR;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dial_tone   <= 1'b0;
            number_done <= 1'b0;
            viol_code   <= 3'd0;
        end else begin
            dial_tone   <= (nxt == S_TONE);
            number_done <= (state == S_COLLECT) && (nxt == S_DONE);
            if (nxt == S_IDLE) begin
                viol_code <= 3'd0;
            end else if ((state != S_ERROR) && (nxt == S_ERROR)) begin
                viol_code <= code_n;
            end
        end
    end

    // R2
    tone_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && off_hook) |=> dial_tone);

    // R3
    tone_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dial_tone && digit_stb && off_hook) |=> !dial_tone);

    // R6
    too_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COLLECT && off_hook && digit_stb && gap_cnt < GAP_MIN_V)
        |=> (viol_code == 3'd3));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        number_done |=> !number_done);

    // R10
    code_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_code != 3'd0 && off_hook) |=> (viol_code == $past(viol_code)));

    // R11
    onhook_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !off_hook |=> (viol_code == 3'd0 && !dial_tone && !number_done));
endmodule

// File: tb/dial_supervisor_tb.sv
module dial_supervisor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P_FIRST = 12;
    localparam int P_GAP   = 10;
    localparam int P_MIN   = 3;
    localparam int P_TOTAL = 30;
    localparam int P_DIG   = 4;

    localparam int MI = 0, MT = 1, MC = 2, MD = 3, ME = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       off_hook = 1'b0;
    logic       digit_stb = 1'b0;
    logic       tick = 1'b0;
    logic       dial_tone;
    logic       number_done;
    logic [2:0] viol_code;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    string cur_req = "R1";

    // requirement-level model state
    int m_st = MI, m_gap = 0, m_tot = 0, m_dig = 0, m_code = 0;
    bit m_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dial_supervisor #(
        .FIRST_MAX_TICKS (P_FIRST),
        .GAP_MAX_TICKS   (P_GAP),
        .GAP_MIN_TICKS   (P_MIN),
        .TOTAL_MAX_TICKS (P_TOTAL),
        .NUM_DIGITS      (P_DIG)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .off_hook    (off_hook),
        .digit_stb   (digit_stb),
        .tick        (tick),
        .dial_tone   (dial_tone),
        .number_done (number_done),
        .viol_code   (viol_code)
    );

    // Edge numbers (counted from the edge that sees the handset up) at which
    // each window trips with a tick on every cycle.
    function automatic int first_to_edge();
        return P_FIRST + 1;          // R4
    endfunction
    function automatic int gap_to_edge(input int digit_edge);
        return digit_edge + P_GAP;   // R5
    endfunction
    function automatic int total_to_edge();
        return P_TOTAL + 1;          // R7
    endfunction

    always @(posedge clk) begin
        m_done = 0;
        if (!rst_n || !off_hook) begin
            m_st = MI; m_gap = 0; m_tot = 0; m_dig = 0; m_code = 0;
        end else begin
            case (m_st)
                MI: begin m_st = MT; m_gap = 0; m_tot = 0; m_dig = 0; end
                MT: begin
                    if (digit_stb) begin
                        m_st = MC; m_dig = 1; m_gap = 0;
                        if (tick) m_tot++;
                    end else if (tick && m_gap + 1 >= P_FIRST) begin
                        m_st = ME; m_code = 1;
                    end else if (tick && m_tot + 1 >= P_TOTAL) begin
                        m_st = ME; m_code = 4;
                    end else if (tick) begin
                        m_gap++; m_tot++;
                    end
                end
                MC: begin
                    if (digit_stb) begin
                        if (m_gap < P_MIN) begin
                            m_st = ME; m_code = 3;
                        end else begin
                            m_dig++; m_gap = 0;
                            if (tick) m_tot++;
                            if (m_dig == P_DIG) begin m_st = MD; m_done = 1; end
                        end
                    end else if (tick && m_gap + 1 >= P_GAP) begin
                        m_st = ME; m_code = 2;
                    end else if (tick && m_tot + 1 >= P_TOTAL) begin
                        m_st = ME; m_code = 4;
                    end else if (tick) begin
                        m_gap++; m_tot++;
                    end
                end
                default: ;
            endcase
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk({cur_req, "/R3"}, "dial_tone", int'(dial_tone), int'(m_st == MT));
        chk({cur_req, "/R9"}, "number_done", int'(number_done), int'(m_done));
        chk({cur_req, "/R10"}, "viol_code", int'(viol_code), m_code);
    endtask

    task automatic step(input logic oh, input logic dg, input logic tk);
        off_hook = oh; digit_stb = dg; tick = tk;
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    // Lift the handset (block must be in IDLE) and run edges 1..n with a
    // tick every cycle and digits at the listed edges (0 = unused).
    task automatic lift_run(input int d1, input int d2, input int d3, input int d4, input int n);
        for (int e = 1; e <= n; e++)
            step(1'b1, (e == d1) || (e == d2) || (e == d3) || (e == d4), 1'b1);
    endtask

    task automatic hang_up();
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20031));
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "dial_tone", int'(dial_tone), 0);
        chk("R1", "number_done", int'(number_done), 0);
        chk("R1", "viol_code", int'(viol_code), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0);
        chk("R1", "viol_code after reset", int'(viol_code), 0);

        // R2 / R4: dial tone, then first-digit timeout
        cur_req = "R4";
        lift_run(0, 0, 0, 0, 1);
        chk("R2", "dial_tone", int'(dial_tone), 1);
        lift_run(0, 0, 0, 0, first_to_edge() - 2);
        chk("R4", "viol before expiry", int'(viol_code), 0);
        chk("R4", "tone before expiry", int'(dial_tone), 1);
        step(1'b1, 1'b0, 1'b1);
        chk("R4", "viol at expiry", int'(viol_code), 1);
        chk("R4", "tone at expiry", int'(dial_tone), 0);
        step(1'b0, 1'b0, 1'b1);
        chk("R11", "viol after on-hook", int'(viol_code), 0);
        step(1'b0, 1'b0, 1'b1);

        // R3 / R9: clean number, digits 5 ticks apart
        cur_req = "R9";
        lift_run(2, 0, 0, 0, 2);
        chk("R3", "tone after first digit", int'(dial_tone), 0);
        for (int e = 3; e <= 17; e++) begin
            step(1'b1, (e == 7) || (e == 12) || (e == 17), 1'b1);
            if (e == 17) chk("R9", "number_done pulse", int'(number_done), 1);
        end
        step(1'b1, 1'b1, 1'b1);
        chk("R9", "number_done after pulse", int'(number_done), 0);
        for (int e = 0; e < 8; e++) step(1'b1, 1'(e % 3 == 0), 1'b1);
        chk("R9", "viol in DONE", int'(viol_code), 0);
        chk("R9", "tone in DONE", int'(dial_tone), 0);
        hang_up();

        // R6 / R10: too-fast digit then sticky code
        cur_req = "R6";
        lift_run(2, 3, 0, 0, 3);
        chk("R6", "viol too fast", int'(viol_code), 3);
        cur_req = "R10";
        for (int e = 0; e < 40; e++) step(1'b1, 1'(e % 4 == 0), 1'b1);
        chk("R10", "viol sticky", int'(viol_code), 3);
        hang_up();

        // R5: inter-digit timeout
        cur_req = "R5";
        lift_run(2, 0, 0, 0, gap_to_edge(2) - 1);
        chk("R5", "viol before expiry", int'(viol_code), 0);
        step(1'b1, 1'b0, 1'b1);
        chk("R5", "viol at expiry", int'(viol_code), 2);
        hang_up();

        // R7: overall timeout with digits 9 ticks apart
        cur_req = "R7";
        lift_run(11, 20, 29, 0, total_to_edge() - 1);
        chk("R7", "viol before total expiry", int'(viol_code), 0);
        step(1'b1, 1'b0, 1'b1);
        chk("R7", "viol total expiry", int'(viol_code), 4);
        hang_up();

        // R8 / R7: digit on the expiring tick wins; gap and total expire together
        cur_req = "R8";
        lift_run(2, 12, 0, 0, 12);
        chk("R8", "digit on expiring tick", int'(viol_code), 0);
        cur_req = "R7";
        for (int e = 13; e <= 31; e++) step(1'b1, e == 21, 1'b1);
        chk("R7", "gap beats total", int'(viol_code), 2);
        hang_up();

        // R11 / R12: hang up mid-number, strobes while down ignored
        cur_req = "R11";
        lift_run(2, 0, 0, 0, 6);
        step(1'b0, 1'b0, 1'b1);
        chk("R11", "tone after on-hook", int'(dial_tone), 0);
        chk("R11", "viol after on-hook", int'(viol_code), 0);
        cur_req = "R12";
        for (int e = 0; e < 6; e++) step(1'b0, 1'b1, 1'b1);
        chk("R12", "tone while down", int'(dial_tone), 0);
        chk("R12", "done while down", int'(number_done), 0);
        lift_run(0, 0, 0, 0, 1);
        chk("R12", "fresh dial tone", int'(dial_tone), 1);
        lift_run(0, 3, 0, 0, 3);
        chk("R12", "first digit accepted fresh", int'(dial_tone), 0);
        chk("R12", "no violation", int'(viol_code), 0);
        hang_up();

        // Random calls checked every cycle against the model
        cur_req = "R5/R6/R7";
        for (int c = 0; c < 300; c++) begin
            int p;
            int len;
            case ($urandom % 4)
                0: p = 2;
                1: p = 5;
                2: p = 9;
                default: p = 16;
            endcase
            len = 20 + int'($urandom % 60);
            for (int e = 0; e < len; e++)
                step(1'($urandom % 250 != 0), 1'($urandom % p == 0), 1'($urandom % 4 != 0));
            for (int e = 0; e < 2 + int'($urandom % 3); e++)
                step(1'b0, 1'($urandom % 2), 1'($urandom % 2));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule